// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the timing strobes that drive a parallel TFT panel: a pixel clock enable derived from the module clock, a divided pixel clock output, a line sync, a frame sync and a data-enable marking the visible area. Panel geometry comes from two packed timing words. Each axis has a sync pulse, then a back porch, then the active region, then a front porch. The horizontal active width is coded in steps of 16 pixels. An integer divisor taken from a control word sets the pixel rate.

The block also reports the active pixel index and active line index, and gives a one-cycle data-request strobe at the start of each visible pixel so that a pixel path can fetch the next value. Polarity inputs invert the pixel clock, line sync and frame sync outputs. A raster enable starts the scan. While the enable is low the scan is held at the first pixel of the first line.

Top module: `lcd_raster_timer`

## Requirements
- R1: `pclk_en` pulses for one module clock every D cycles, where D is `ctrl_word[15:8]`; divisor values 0 and 1 act as D = 2. The first pulse comes D-1 cycles after the first enabled cycle.
- R2: `pclk_out` is high for the first floor(D/2) cycles of each pixel period and low for the rest, so it is low in the cycle that `pclk_en` pulses. The level is inverted when `inv_pclk` = 1.
- R3: A line lasts (HS+1)+(HB+1)+16*(W+1)+(HF+1) pixel periods. The fields are HB = `htim_word[31:24]`, HF = `htim_word[23:16]`, HS = `htim_word[15:10]` and W = `htim_word[9:4]`, which gives at most 1024 active pixels.
- R4: `lsync` is active during the first HS+1 pixel periods of every line (sync, back porch, active, front porch in that order).
- R5: A frame lasts (VS+1)+(VB+1)+(L+1)+(VF+1) lines. The fields are VB = `vtim_word[31:24]`, VF = `vtim_word[23:16]`, VS = `vtim_word[15:10]` and L = `vtim_word[9:0]`. `fsync` is active during the first VS+1 lines.
- R6: `de` is high only during active pixels of active lines. `pix_x` counts 0 to width-1 across the horizontal active region and is 0 elsewhere. `line_y` counts 0 to L across the vertical active region and is 0 elsewhere.
- R7: `data_req` pulses for one module clock in the first cycle of each active pixel and is never high without `de`.
- R8: `inv_lsync` and `inv_fsync` invert the active level of `lsync` and `fsync`. Active is high when the inversion bit is 0.
- R9: While `raster_en` is 0, the syncs sit at their inactive level, `de`, `data_req` and `pclk_en` are 0, `pix_x`/`line_y` are 0, `pclk_out` equals `inv_pclk`, and the scan is cleared. When the enable goes high, line sync and frame sync both become active in the same cycle.
- R10: Every frame sync start coincides with a line sync start in the same module clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raster_en | input | 1 | Starts and holds the scan |
| ctrl_word | input | 32 | Control word, pixel divisor at bits 15:8 |
| htim_word | input | 32 | Horizontal timing word |
| vtim_word | input | 32 | Vertical timing word |
| inv_pclk | input | 1 | Invert pixel clock output |
| inv_lsync | input | 1 | Invert line sync output |
| inv_fsync | input | 1 | Invert frame sync output |
| pclk_en | output | 1 | One-cycle pixel advance strobe |
| pclk_out | output | 1 | Divided pixel clock to the panel |
| lsync | output | 1 | Line sync |
| fsync | output | 1 | Frame sync |
| de | output | 1 | Active data enable |
| data_req | output | 1 | Request strobe for the next pixel value |
| pix_x | output | 10 | Active pixel index |
| line_y | output | 10 | Active line index |

## Verification
The line counter wrapping at the end of a front porch and the frame counter wrapping at the end of the vertical front porch fall on the same pixel-clock enable. The same happens when the enable is first raised, because both axes start in their sync phase together. The bench runs whole frames under several geometries and divisors. At every frame sync start it checks that a line sync start was seen in that same sampled cycle, and it checks that the frame period is an exact multiple of the measured line period. It also drops the enable in the middle of a frame and checks that the next scan again opens with both syncs together.

// File: rtl/lrt_pkg.sv
// Shared types for the raster timer: scan phase encoding, per-axis
// timing record and the decoders that unpack the timing words.
// Assumes the fixed field positions of the horizontal and vertical words.
package lrt_pkg;

    localparam int LRT_ACT_W   = 10;
    localparam int LRT_PORCH_W = 8;
    localparam int LRT_SYNC_W  = 6;

    typedef enum logic [1:0] {
        PH_SYNC   = 2'd0,
        PH_BACK   = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_FRONT  = 2'd3
    } lrt_phase_e;

    typedef struct packed {
        logic [LRT_PORCH_W-1:0] back;
        logic [LRT_PORCH_W-1:0] front;
        logic [LRT_SYNC_W-1:0]  sync;
        logic [LRT_ACT_W-1:0]   act_m1;
    } lrt_axis_t;

    // Horizontal: width in 16-pixel steps, so length-1 is {field, 4'hF}
    function automatic lrt_axis_t lrt_decode_h(input logic [31:4] w);
        lrt_axis_t r;
        r.back   = w[31:24];
        r.front  = w[23:16];
        r.sync   = w[15:10];
        r.act_m1 = {w[9:4], 4'hF};
        return r;
    endfunction

    // Vertical: line count minus one held directly in the low field
    function automatic lrt_axis_t lrt_decode_v(input logic [31:0] w);
        lrt_axis_t r;
        r.back   = w[31:24];
        r.front  = w[23:16];
        r.sync   = w[15:10];
        r.act_m1 = w[9:0];
        return r;
    endfunction

    // Phase sequence: sync, back porch, active, front porch, repeat
    function automatic lrt_phase_e lrt_next_phase(input lrt_phase_e p);
        case (p)
            PH_SYNC:   return PH_BACK;
            PH_BACK:   return PH_ACTIVE;
            PH_ACTIVE: return PH_FRONT;
            default:   return PH_SYNC;
        endcase
    endfunction

endpackage

// File: rtl/lrt_clkdiv.sv
// Pixel rate divider. Emits a one-cycle tick every D module clocks and a
// divided clock level (high in the first half of the period).
// Assumes divisor values below 2 must be raised to 2 so tick never sticks.
module lrt_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  logic             inv,
    output logic             tick,
    output logic             clk_lvl
);

    localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] cnt;
    logic             last;

    // Clamp the divisor to at least two
    always_comb div_eff = (div < DIV_MIN) ? DIV_MIN : div;

    // Final cycle of the pixel period (>= guards a divisor lowered mid-period)
    always_comb last = (cnt >= div_eff - DIV_W'(1));

    // Period counter, cleared while the raster is off
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

    // Tick and clock level outputs
    always_comb begin
        tick    = en && last;
        clk_lvl = (en && (cnt < (div_eff >> 1))) ^ inv;
    end

    // Spacing is at least two cycles, so ticks never touch
    assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/lrt_axis_ctr.sv
// One scan axis: walks sync, back porch, active and front porch phases,
// each lasting field+1 steps, and flags the step that closes the axis.
// Assumes cfg is held steady while en is high.
module lrt_axis_ctr
    import lrt_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             step,
    input  lrt_axis_t        cfg,
    output logic [CNT_W-1:0] pos,
    output logic             in_sync,
    output logic             in_active,
    output logic             wrap
);

    lrt_phase_e       phase;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] len_m1;
    logic             last;

    // Length minus one of the current phase
    always_comb begin
        case (phase)
            PH_SYNC:   len_m1 = CNT_W'(cfg.sync);
            PH_BACK:   len_m1 = CNT_W'(cfg.back);
            PH_ACTIVE: len_m1 = CNT_W'(cfg.act_m1);
            default:   len_m1 = CNT_W'(cfg.front);
        endcase
    end

    // Phase end and axis wrap detection
    always_comb begin
        last      = (cnt == len_m1);
        wrap      = step && last && (phase == PH_FRONT);
        in_sync   = (phase == PH_SYNC);
        in_active = (phase == PH_ACTIVE);
        pos       = in_active ? cnt : '0;
    end

    // Phase and position state, held at the start while disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            phase <= PH_SYNC;
            cnt   <= '0;
        end else if (step) begin
            if (last) begin
                phase <= lrt_next_phase(phase);
                cnt   <= '0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // Without a step the axis state must not move
    assert_hold_without_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !$past(step)) |-> ($stable(phase) && $stable(cnt)));

endmodule

// File: rtl/lcd_raster_timer.sv
// Raster timing generator for a parallel TFT panel. Combines the pixel
// divider with a horizontal and a vertical axis counter and shapes the
// panel strobes, polarity and pixel request. Assumes all configuration
// is set before raster_en is raised and left alone while it is high.
module lcd_raster_timer
    import lrt_pkg::*;
#(
    parameter int POS_W   = 10,
    parameter int DIV_W   = 8,
    parameter int DIV_LSB = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raster_en,
    input  logic [31:0]      ctrl_word,
    input  logic [31:0]      htim_word,
    input  logic [31:0]      vtim_word,
    input  logic             inv_pclk,
    input  logic             inv_lsync,
    input  logic             inv_fsync,
    output logic             pclk_en,
    output logic             pclk_out,
    output logic             lsync,
    output logic             fsync,
    output logic             de,
    output logic             data_req,
    output logic [POS_W-1:0] pix_x,
    output logic [POS_W-1:0] line_y
);

    localparam int DIV_HI = DIV_LSB + DIV_W;

    lrt_axis_t        h_cfg, v_cfg;
    logic             tick, tick_d;
    logic             h_sync, h_act, h_wrap;
    logic             v_sync, v_act, v_wrap;
    logic [POS_W-1:0] h_pos, v_pos;
    logic             unused_cfg_bits;

    // Unpack the timing words
    always_comb begin
        h_cfg = lrt_decode_h(htim_word[31:4]);
        v_cfg = lrt_decode_v(vtim_word);
    end

    // Fields outside the decoded ones carry no meaning here
    assign unused_cfg_bits = ^{ctrl_word[31:DIV_HI], ctrl_word[DIV_LSB-1:0],
                               htim_word[3:0], v_wrap};

    lrt_clkdiv #(.DIV_W(DIV_W)) i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (raster_en),
        .div     (ctrl_word[DIV_HI-1:DIV_LSB]),
        .inv     (inv_pclk),
        .tick    (tick),
        .clk_lvl (pclk_out)
    );

    lrt_axis_ctr #(.CNT_W(POS_W)) i_hax (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (raster_en),
        .step      (tick),
        .cfg       (h_cfg),
        .pos       (h_pos),
        .in_sync   (h_sync),
        .in_active (h_act),
        .wrap      (h_wrap)
    );

    lrt_axis_ctr #(.CNT_W(POS_W)) i_vax (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (raster_en),
        .step      (h_wrap),
        .cfg       (v_cfg),
        .pos       (v_pos),
        .in_sync   (v_sync),
        .in_active (v_act),
        .wrap      (v_wrap)
    );

    // Marks the first module cycle of each new pixel period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_d <= 1'b0;
        end else begin
            tick_d <= tick;
        end
    end

    // Panel strobes with polarity, forced idle while disabled
    always_comb begin
        pclk_en  = tick;
        lsync    = (raster_en && h_sync) ^ inv_lsync;
        fsync    = (raster_en && v_sync) ^ inv_fsync;
        de       = raster_en && h_act && v_act;
        data_req = de && tick_d;
        pix_x    = raster_en ? h_pos : '0;
        line_y   = raster_en ? v_pos : '0;
    end

    // A frame may only open at the same edge that opens a line
    assert_frame_on_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(v_sync) |-> $rose(h_sync));

    // Data enable changes only at a pixel boundary
    assert_de_on_pixel_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (raster_en && $past(raster_en) && !$past(tick)) |-> $stable(de));

    // Disabled cycle leaves both axes at their start
    assert_idle_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !raster_en |=> (h_sync && v_sync && h_pos == '0 && v_pos == '0));

    // A request never stands alone outside the active area
    assert_req_needs_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        data_req |-> $past(tick));

endmodule

// File: tb/test_lcd_raster_timer.sv
module test_lcd_raster_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        raster_en = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic [31:0] htim_word = '0;
    logic [31:0] vtim_word = '0;
    logic        inv_pclk = 1'b0, inv_lsync = 1'b0, inv_fsync = 1'b0;
    logic        pclk_en, pclk_out, lsync, fsync, de, data_req;
    logic [9:0]  pix_x, line_y;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // measurement results
    int ls_n, fs_n, ls_t0, ls_t1, fs_t0, fs_t1, ls_w, fs_w;
    int pc_n, pc_t0, pc_t1, pclk_bad, coin_bad, stray;
    int de_n, dreq_n, maxx, maxy, maxx_l;

    always #4 clk = ~clk;

    lcd_raster_timer i_lcd_raster_timer (
        .clk(clk), .rst_n(rst_n), .raster_en(raster_en),
        .ctrl_word(ctrl_word), .htim_word(htim_word), .vtim_word(vtim_word),
        .inv_pclk(inv_pclk), .inv_lsync(inv_lsync), .inv_fsync(inv_fsync),
        .pclk_en(pclk_en), .pclk_out(pclk_out), .lsync(lsync), .fsync(fsync),
        .de(de), .data_req(data_req), .pix_x(pix_x), .line_y(line_y)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_h(int bp, int fp, int sw, int w16);
        return {8'(bp), 8'(fp), 6'(sw), 6'(w16), 4'h0};
    endfunction

    function automatic logic [31:0] mk_v(int bp, int fp, int sw, int l);
        return {8'(bp), 8'(fp), 6'(sw), 10'(l)};
    endfunction

    function automatic int eff_div(int d);
        return (d < 2) ? 2 : d;
    endfunction

    // disable, apply configuration, then raise the enable on a falling edge
    task automatic start(input int d, input logic [31:0] h, input logic [31:0] v,
                         input bit ip, input bit il, input bit ifr);
        @(negedge clk);
        raster_en = 1'b0;
        repeat (3) @(negedge clk);
        ctrl_word = {16'h0, 8'(d), 8'h0};
        htim_word = h; vtim_word = v;
        inv_pclk = ip; inv_lsync = il; inv_fsync = ifr;
        @(negedge clk);
        raster_en = 1'b1;
    endtask

    // sample ncyc cycles starting in the enable cycle itself
    task automatic measure(input int ncyc);
        bit pl = 0, pf = 0, pe = 0, al, af, lr;
        ls_n = 0; fs_n = 0; ls_t0 = -1; ls_t1 = -1; fs_t0 = -1; fs_t1 = -1;
        ls_w = -1; fs_w = -1; pc_n = 0; pc_t0 = -1; pc_t1 = -1;
        pclk_bad = 0; coin_bad = 0; stray = 0; de_n = 0; dreq_n = 0;
        maxx = 0; maxy = 0; maxx_l = 0;
        for (int t = 0; t < ncyc; t++) begin
            #1;
            al = lsync ^ inv_lsync;
            af = fsync ^ inv_fsync;
            if (pclk_en) begin
                if (pc_n == 0) pc_t0 = t; else if (pc_n == 1) pc_t1 = t;
                pc_n++;
                if (pclk_out !== inv_pclk) pclk_bad++;
            end
            if (pe && pclk_out !== ~inv_pclk) pclk_bad++;
            pe = pclk_en;
            lr = al && !pl;
            if (lr) begin
                if (ls_n == 0) ls_t0 = t; else if (ls_n == 1) ls_t1 = t;
                ls_n++;
            end
            if (!al && pl && ls_w < 0) ls_w = t - ls_t0;
            if (af && !pf) begin
                if (fs_n == 0) fs_t0 = t; else if (fs_n == 1) fs_t1 = t;
                fs_n++;
                if (!lr) coin_bad++;
            end
            if (!af && pf && fs_w < 0) fs_w = t - fs_t0;
            if (fs_n == 1) begin
                de_n += int'(de);
                dreq_n += int'(data_req);
                if (int'(pix_x) > maxx) maxx = int'(pix_x);
                if (de && int'(line_y) > maxy) maxy = int'(line_y);
            end
            if (ls_n == 1 && int'(pix_x) > maxx_l) maxx_l = int'(pix_x);
            if (data_req && !de) stray++;
            pl = al; pf = af;
            @(negedge clk);
        end
    endtask

    // full-frame scenario with expected values from the requirements
    task automatic t_frame(input int d, input int hs, input int hb, input int w16,
                           input int hf, input int vs, input int vb, input int l,
                           input int vf, input bit ip, input bit il, input bit ifr);
        int dd = eff_div(d);
        int width = 16 * (w16 + 1);
        int line_cyc = dd * ((hs + 1) + (hb + 1) + width + (hf + 1));
        int lines = (vs + 1) + (vb + 1) + (l + 1) + (vf + 1);
        int frame_cyc = line_cyc * lines;
        start(d, mk_h(hb, hf, hs, w16), mk_v(vb, vf, vs, l), ip, il, ifr);
        measure(2 * frame_cyc + 4);
        check("R1 pclk_en spacing", pc_t1 - pc_t0, dd);
        check("R1 first pclk_en", pc_t0, dd - 1);
        check("R2 pclk_out shape", pclk_bad, 0);
        check("R3 line period", ls_t1 - ls_t0, line_cyc);
        check("R4 lsync width", ls_w, (hs + 1) * dd);
        check("R5 frame period", fs_t1 - fs_t0, frame_cyc);
        check("R5 fsync width", fs_w, (vs + 1) * line_cyc);
        check("R6 de cycles per frame", de_n, (l + 1) * width * dd);
        check("R6 max pix_x", maxx, width - 1);
        check("R6 max pix_x first line", maxx_l, width - 1);
        check("R6 max line_y", maxy, l);
        check("R7 data_req per frame", dreq_n, (l + 1) * width);
        check("R7 data_req outside de", stray, 0);
        check("R10 frame start off line start", coin_bad, 0);
        check("R9 syncs open at enable", ls_t0 + fs_t0, 0);
        if (il || ifr) check("R8 inverted syncs seen", ls_n > 0 && fs_n > 0, 1);
    endtask

    task automatic t_reset();
        #1;
        check("R9 reset lsync", lsync, 0);
        check("R9 reset fsync", fsync, 0);
        check("R9 reset de", de, 0);
        check("R9 reset pclk_en", pclk_en, 0);
        check("R9 reset pclk_out", pclk_out, 0);
        check("R9 reset pix_x", int'(pix_x), 0);
        check("R9 reset line_y", int'(line_y), 0);
    endtask

    // idle levels with inversion and a mid-frame stop and restart
    task automatic t_disable();
        start(3, mk_h(1, 0, 1, 0), mk_v(0, 0, 0, 2), 1, 1, 1);
        repeat (150) @(negedge clk);
        raster_en = 1'b0;
        #1;
        check("R8 idle lsync inverted", lsync, 1);
        check("R8 idle fsync inverted", fsync, 1);
        repeat (3) @(negedge clk);
        #1;
        check("R9 off pclk_out", pclk_out, 1);
        check("R9 off de", de, 0);
        check("R9 off data_req", data_req, 0);
        check("R9 off pclk_en", pclk_en, 0);
        check("R9 off pix_x", int'(pix_x), 0);
        check("R9 off line_y", int'(line_y), 0);
        @(negedge clk);
        raster_en = 1'b1;
        measure(200);
        check("R9 restart lsync at enable", ls_t0, 0);
        check("R9 restart fsync at enable", fs_t0, 0);
        check("R9 restart line period", ls_t1 - ls_t0, 3 * (2 + 2 + 16 + 1));
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_frame(2, 1, 2, 0, 0, 0, 1, 3, 0, 0, 0, 0);
        t_frame(2, 0, 3, 1, 2, 2, 0, 1, 3, 0, 0, 0);
        t_frame(0, 1, 2, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        t_frame(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        t_frame(5, 2, 1, 0, 1, 1, 0, 1, 0, 0, 0, 0);
        t_frame(3, 1, 2, 0, 0, 0, 1, 3, 0, 1, 1, 1);
        t_frame(2, 0, 0, 63, 0, 0, 0, 0, 0, 0, 0, 0);
        t_disable();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule